// File: doc/BRIEF.md
# Comparator Control and Edge-Flag Register

This block is the digital side of an on-chip analog comparator. It holds one 16-bit register on a simple synchronous bus. The register carries:

- an enable bit;
- a two-bit select for the comparator's negative input;
- a two-bit route code that sends the result to a pin or to an interrupt request;
- a polarity bit;
- a two-bit response-speed select;
- a hysteresis enable.

The enable, negative-input select, response-speed select and hysteresis bit are driven straight out to the analog macro. A one-bit digital compare result stands in for the analog output.

The compare result enters through a two-stage synchronizer. The block watches the synchronized level for edges. While the comparator is enabled, a rising edge sets a sticky rise flag and a falling edge sets a sticky fall flag. Software clears each flag by writing a one to it. The polarity bit inverts the level that reaches the pin output. The interrupt request is raised whenever either flag is set and the route code selects the interrupt.

Top module: `cmp_ctrl_reg`

## Requirements
- R1: After reset, the register reads 0x0000, and every configuration output, the pin output and the interrupt output are low.
- R2: A write at the register address loads bits 10 down to 2 from the write data. Bits 15 to 11 always read 0. A read at the register address returns the register in the same cycle. A read at any other address returns 0, and a write at any other address changes nothing.
- R3: Four outputs follow their register fields. The enable output follows bit 10. The negative-input select follows bits 9:8, with 00 for half supply, 01 for an ADC channel and 10 for a DAC output. The response select follows bits 4:3. The hysteresis output follows bit 2.
- R4: A low-to-high change of the compare input sets bit 1 (rise flag) exactly three clock edges after the input is sampled, provided bit 10 was set when the synchronized edge was seen.
- R5: A high-to-low change of the compare input sets bit 0 (fall flag) with the same three-edge latency and under the same enable condition.
- R6: While bit 10 is clear, changes of the compare input never set either flag.
- R7: Writing 1 to bit 1 or bit 0 clears that flag. Writing 0 to either bit leaves it unchanged.
- R8: If a hardware set and a software clear reach the same flag on the same clock edge, the flag ends up set.
- R9: The pin output is high only when three conditions hold:
  - bit 10 is set;
  - route bits 7:6 equal 10;
  - the synchronized compare level XOR polarity bit 5 is 1.

  The pin output changes two edges after the input is sampled.
- R10: The interrupt output equals (rise flag OR fall flag) when route bits 7:6 equal 11, and is low for any other route code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Bus access select |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Access address |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Read data, 0 when not addressed |
| rawCmp | input | 1 | Asynchronous compare result |
| cmpEnable | output | 1 | Comparator enable to analog side |
| negSel | output | 2 | Negative-input select |
| respSel | output | 2 | Response-speed select |
| hystEn | output | 1 | Hysteresis enable |
| cmpPin | output | 1 | Polarity-adjusted result to the pin |
| cmpIrq | output | 1 | Edge-flag interrupt request |

## Verification
The colliding functions are the hardware edge detector and the software write-one-clear. Both can target the same flag on the same edge.

The bench provokes the collision by raising the compare input and then issuing a clearing write at a sweep of delays. One delay lands exactly on the edge where the synchronized rise is detected. A behavioural model that applies the clear before the set judges every cycle of the sweep. A directed read at the exact collision point expects the flag to remain set.

// File: rtl/cmp_ctrl_pkg.sv
package cmp_ctrl_pkg;
  localparam int REG_W    = 16;
  localparam int CFG_MSB  = 10;
  localparam int BIT_EN   = 10;
  localparam int NEG_LO   = 8;
  localparam int ROUTE_LO = 6;
  localparam int BIT_POL  = 5;
  localparam int RESP_LO  = 3;
  localparam int BIT_HYST = 2;
  localparam int BIT_RISE = 1;
  localparam int BIT_FALL = 0;
  localparam int RSV_W    = REG_W - CFG_MSB - 1;

  typedef enum logic [1:0] {
    ROUTE_RSV0 = 2'b00,
    ROUTE_RSV1 = 2'b01,
    ROUTE_PIN  = 2'b10,
    ROUTE_IRQ  = 2'b11
  } route_e;

  typedef struct packed {
    logic cfgLoad;
    logic clrRise;
    logic clrFall;
    logic rdHit;
  } strobe_t;
endpackage

// File: rtl/cmp_ctrl_ctl.sv
module cmp_ctrl_ctl
  import cmp_ctrl_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] REG_ADDR = 12'h444
) (
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              wrRiseBit,
  input  logic              wrFallBit,
  output strobe_t           stb
);
  logic addrHit;

  assign addrHit = busSel && (busAddr == REG_ADDR);

  always_comb begin
    stb.cfgLoad = addrHit && busWr;
    stb.clrRise = addrHit && busWr && wrRiseBit;
    stb.clrFall = addrHit && busWr && wrFallBit;
    stb.rdHit   = addrHit && !busWr;
  end
endmodule

// File: rtl/cmp_ctrl_dp.sv
module cmp_ctrl_dp
  import cmp_ctrl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          stb,
  input  logic [CFG_MSB:0] wrData,
  input  logic             rawCmp,
  output logic [REG_W-1:0] regVal,
  output logic [REG_W-1:0] rdData,
  output logic             cmpEnable,
  output logic [1:0]       negSel,
  output logic [1:0]       respSel,
  output logic             hystEn,
  output logic             cmpPin,
  output logic             cmpIrq
);
  logic       enQ, polQ, hystQ, riseQ, fallQ;
  logic [1:0] negQ, respQ;
  route_e     routeQ;
  logic [SYNC_STAGES-1:0] syncQ;
  logic       prevQ, syncLvl, riseHit, fallHit;
  logic       unusedWr;

  assign unusedWr = wrData[BIT_RISE] ^ wrData[BIT_FALL];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enQ    <= 1'b0;
      negQ   <= 2'b00;
      routeQ <= ROUTE_RSV0;
      polQ   <= 1'b0;
      respQ  <= 2'b00;
      hystQ  <= 1'b0;
    end else if (stb.cfgLoad) begin
      enQ    <= wrData[BIT_EN];
      negQ   <= wrData[NEG_LO+1:NEG_LO];
      routeQ <= route_e'(wrData[ROUTE_LO+1:ROUTE_LO]);
      polQ   <= wrData[BIT_POL];
      respQ  <= wrData[RESP_LO+1:RESP_LO];
      hystQ  <= wrData[BIT_HYST];
    end
  end

  generate
    if (SYNC_STAGES > 1) begin : gSyncChain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= {syncQ[SYNC_STAGES-2:0], rawCmp};
      end
    end else begin : gSyncSingle
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= rawCmp;
      end
    end
  endgenerate

  assign syncLvl = syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevQ <= 1'b0;
    else       prevQ <= syncLvl;
  end

  assign riseHit = enQ && syncLvl && !prevQ;
  assign fallHit = enQ && !syncLvl && prevQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      riseQ <= 1'b0;
      fallQ <= 1'b0;
    end else begin
      riseQ <= riseHit || (riseQ && !stb.clrRise);
      fallQ <= fallHit || (fallQ && !stb.clrFall);
    end
  end

  assign regVal    = {{RSV_W{1'b0}}, enQ, negQ, routeQ, polQ, respQ, hystQ, riseQ, fallQ};
  assign rdData    = stb.rdHit ? regVal : '0;
  assign cmpEnable = enQ;
  assign negSel    = negQ;
  assign respSel   = respQ;
  assign hystEn    = hystQ;
  assign cmpPin    = enQ && (routeQ == ROUTE_PIN) && (syncLvl ^ polQ);
  assign cmpIrq    = (routeQ == ROUTE_IRQ) && (riseQ || fallQ);
endmodule

// File: rtl/cmp_ctrl_reg.sv
module cmp_ctrl_reg
  import cmp_ctrl_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] REG_ADDR = 12'h444,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [15:0]       busWdata,
  output logic [15:0]       busRdata,
  input  logic              rawCmp,
  output logic              cmpEnable,
  output logic [1:0]        negSel,
  output logic [1:0]        respSel,
  output logic              hystEn,
  output logic              cmpPin,
  output logic              cmpIrq
);
  strobe_t          stb;
  logic [REG_W-1:0] regVal;
  logic [RSV_W-1:0] unusedWdata;

  assign unusedWdata = busWdata[REG_W-1:CFG_MSB+1];

  cmp_ctrl_ctl #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) uCtl (
    .busSel    (busSel),
    .busWr     (busWr),
    .busAddr   (busAddr),
    .wrRiseBit (busWdata[BIT_RISE]),
    .wrFallBit (busWdata[BIT_FALL]),
    .stb       (stb)
  );

  cmp_ctrl_dp #(.SYNC_STAGES(SYNC_STAGES)) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .wrData    (busWdata[CFG_MSB:0]),
    .rawCmp    (rawCmp),
    .regVal    (regVal),
    .rdData    (busRdata),
    .cmpEnable (cmpEnable),
    .negSel    (negSel),
    .respSel   (respSel),
    .hystEn    (hystEn),
    .cmpPin    (cmpPin),
    .cmpIrq    (cmpIrq)
  );
endmodule

// File: rtl/cmp_ctrl_chk.sv
module cmp_ctrl_chk #(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] REG_ADDR = 12'h444,
  parameter int SYNC_STAGES = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              busSel,
  input logic              busWr,
  input logic [ADDR_W-1:0] busAddr,
  input logic              wrRiseBit,
  input logic [4:0]        rdRsv,
  input logic              rawCmp,
  input logic              cmpPin,
  input logic              cmpIrq,
  input logic              enBit,
  input logic [1:0]        routeBits,
  input logic              riseBit,
  input logic              fallBit
);
  logic [SYNC_STAGES:0] shadow;
  logic wrHit, synced, prior;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shadow <= '0;
    else       shadow <= {shadow[SYNC_STAGES-1:0], rawCmp};
  end

  assign synced = shadow[SYNC_STAGES-1];
  assign prior  = shadow[SYNC_STAGES];
  assign wrHit  = busSel && busWr && (busAddr == REG_ADDR);

  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    rdRsv == 5'b0); // R2
  AST_RISE_SETS: assert property (@(posedge clk) disable iff (!rstN)
    (enBit && synced && !prior) |=> riseBit); // R4
  AST_FALL_SETS: assert property (@(posedge clk) disable iff (!rstN)
    (enBit && !synced && prior) |=> fallBit); // R5
  AST_NO_EDGE_DISABLED: assert property (@(posedge clk) disable iff (!rstN)
    (!enBit && !wrHit) |=> ($stable(riseBit) && $stable(fallBit))); // R6
  AST_W1C_RISE: assert property (@(posedge clk) disable iff (!rstN)
    (wrHit && wrRiseBit && !(enBit && synced && !prior)) |=> !riseBit); // R7
  AST_PIN_GATED: assert property (@(posedge clk) disable iff (!rstN)
    cmpPin |-> (enBit && routeBits == 2'b10)); // R9
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rstN)
    cmpIrq |-> (routeBits == 2'b11 && (riseBit || fallBit))); // R10
endmodule

bind cmp_ctrl_reg cmp_ctrl_chk #(
  .ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR), .SYNC_STAGES(SYNC_STAGES)
) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .busSel    (busSel),
  .busWr     (busWr),
  .busAddr   (busAddr),
  .wrRiseBit (busWdata[1]),
  .rdRsv     (busRdata[15:11]),
  .rawCmp    (rawCmp),
  .cmpPin    (cmpPin),
  .cmpIrq    (cmpIrq),
  .enBit     (regVal[10]),
  .routeBits (regVal[7:6]),
  .riseBit   (regVal[1]),
  .fallBit   (regVal[0])
);

// File: tb/sim_cmp_ctrl_reg.sv
`timescale 1ns/1ps
module sim_cmp_ctrl_reg;
  localparam logic [11:0] ADDR = 12'h444;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busSel = 1'b0, busWr = 1'b0;
  logic [11:0] busAddr = '0;
  logic [15:0] busWdata = '0;
  logic rawCmp = 1'b0;
  logic [15:0] busRdata;
  logic cmpEnable, hystEn, cmpPin, cmpIrq;
  logic [1:0] negSel, respSel;

  int checks = 0, failures = 0, cyc = 0;
  bit checkOn = 0;

  logic [15:0] mReg = '0;
  bit mSync[$] = '{1'b0, 1'b0};
  bit mPrev = 1'b0;

  always #10 clk = ~clk;

  cmp_ctrl_reg u0 (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .rawCmp(rawCmp),
    .cmpEnable(cmpEnable), .negSel(negSel), .respSel(respSel), .hystEn(hystEn),
    .cmpPin(cmpPin), .cmpIrq(cmpIrq)
  );

  // reference model: clear applied first, hardware set afterwards
  always @(posedge clk) begin
    if (!rstN) begin
      mReg = '0; mSync = '{1'b0, 1'b0}; mPrev = 1'b0;
    end else begin
      bit lvl, rise, fall;
      lvl  = mSync[1];
      rise = mReg[10] && lvl && !mPrev;
      fall = mReg[10] && !lvl && mPrev;
      if (busSel && busWr && busAddr == ADDR) begin
        mReg[10:2] = busWdata[10:2];
        if (busWdata[1]) mReg[1] = 1'b0;
        if (busWdata[0]) mReg[0] = 1'b0;
      end
      if (rise) mReg[1] = 1'b1;
      if (fall) mReg[0] = 1'b1;
      mPrev = lvl;
      mSync.push_front(rawCmp);
      void'(mSync.pop_back());
    end
  end

  task automatic checkEq(string tag, string what, int act, int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (checkOn) begin
      logic [15:0] expRd;
      expRd = (busSel && !busWr && busAddr == ADDR) ? mReg : 16'h0;
      checkEq("R2", "busRdata", busRdata, expRd);
      checkEq("R3", "cmpEnable", cmpEnable, mReg[10]);
      checkEq("R3", "negSel", negSel, mReg[9:8]);
      checkEq("R3", "respSel", respSel, mReg[4:3]);
      checkEq("R3", "hystEn", hystEn, mReg[2]);
      checkEq("R9", "cmpPin", cmpPin,
              mReg[10] && mReg[7:6] == 2'b10 && (mSync[1] ^ mReg[5]));
      checkEq("R10", "cmpIrq", cmpIrq,
              mReg[7:6] == 2'b11 && (mReg[1] || mReg[0]));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [11:0] a, logic [15:0] d);
    @(negedge clk); #1;
    busSel = 1; busWr = 1; busAddr = a; busWdata = d;
    @(negedge clk); #1;
    busSel = 0; busWr = 0;
  endtask

  task automatic rdCheck(logic [11:0] a, logic [15:0] exp, string tag);
    @(negedge clk); #1;
    busSel = 1; busWr = 0; busAddr = a;
    @(negedge clk);
    checkEq(tag, "read", busRdata, exp);
    #1; busSel = 0;
  endtask

  task automatic setRaw(bit v);
    @(negedge clk); #1; rawCmp = v;
  endtask

  initial begin
    idle(3);
    checkEq("R1", "reset read", busRdata, 0);
    checkEq("R1", "reset pin/irq/en", {cmpPin, cmpIrq, cmpEnable}, 0);
    #1; rstN = 1; checkOn = 1;
    rdCheck(ADDR, 16'h0000, "R1");

    // R2: config bits only, flags write-one-clear, reserved zero
    wr(ADDR, 16'hFFFF);
    rdCheck(ADDR, 16'h07FC, "R2");
    wr(12'h440, 16'h0000);
    rdCheck(ADDR, 16'h07FC, "R2");
    rdCheck(12'h448, 16'h0000, "R2");

    // R3: field patterns
    wr(ADDR, 16'h0318);
    checkEq("R3", "negSel", negSel, 2'b11);
    checkEq("R3", "respSel", respSel, 2'b11);
    wr(ADDR, 16'h0104);
    checkEq("R3", "hystEn", hystEn, 1);

    // R9: pin route, both polarities
    wr(ADDR, 16'h0480);
    setRaw(1); idle(3);
    checkEq("R9", "pin follows", cmpPin, 1);
    wr(ADDR, 16'h04A0);
    checkEq("R9", "pin inverted", cmpPin, 0);
    setRaw(0); idle(3);
    checkEq("R9", "pin inverted low in", cmpPin, 1);

    // R4/R5/R10: edges into irq route
    wr(ADDR, 16'h04C3);
    rdCheck(ADDR, 16'h04C0, "R7");
    setRaw(1); idle(4);
    rdCheck(ADDR, 16'h04C2, "R4");
    checkEq("R10", "irq", cmpIrq, 1);
    setRaw(0); idle(4);
    rdCheck(ADDR, 16'h04C3, "R5");

    // R7: zero leaves flags, one clears
    wr(ADDR, 16'h04C0);
    rdCheck(ADDR, 16'h04C3, "R7");
    wr(ADDR, 16'h04C1);
    rdCheck(ADDR, 16'h04C2, "R7");
    wr(ADDR, 16'h04C2);
    rdCheck(ADDR, 16'h04C0, "R7");
    checkEq("R10", "irq low", cmpIrq, 0);

    // R8: clear lands on the detecting edge
    setRaw(1); idle(1);
    wr(ADDR, 16'h04C2);
    rdCheck(ADDR, 16'h04C2, "R8");
    setRaw(0); idle(4);
    wr(ADDR, 16'h04C3);

    // R8 sweep judged by model
    for (int d = 0; d < 5; d++) begin
      setRaw(1); idle(d);
      wr(ADDR, 16'h04C2); idle(4);
      setRaw(0); idle(d);
      wr(ADDR, 16'h04C1); idle(4);
      wr(ADDR, 16'h04C3);
    end

    // R6: disabled, no flags
    wr(ADDR, 16'h00C3);
    setRaw(1); idle(4); setRaw(0); idle(4);
    rdCheck(ADDR, 16'h00C0, "R6");
    checkEq("R6", "irq disabled", cmpIrq, 0);

    // mixed traffic, model judged
    for (int i = 0; i < 600; i++) begin
      int op;
      op = $urandom_range(0, 3);
      if (op == 0) wr(($urandom_range(0, 3) == 0) ? 12'h044 : ADDR, 16'($urandom));
      else if (op == 1) setRaw(1'($urandom));
      else if (op == 2) begin
        @(negedge clk); #1; busSel = 1; busWr = 0; busAddr = ADDR;
        @(negedge clk); #1; busSel = 0;
      end else idle(1);
    end

    idle(2);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule